// File: doc/BRIEF.md
# PLL Lock Acquisition Sequencer

This block sequences the acquisition of lock for a phase-locked microwave oscillator. After a start request it selects reference crystals one at a time. After every crystal change it lets the inner loop settle. It then watches two comparator flags. The first is a search-range flag, which shows that the current crystal cannot be captured. The second is a phase-lock-detect flag.

When lock detect has been held for a fixed confirmation interval, the crystal choice is frozen. The block then recenters the oscillator. It walks an 8-bit correction code for the offset-oscillator DAC toward the point where the phase error reads zero. After that it enables the sweep path.

If the correction code runs out of range, the whole sequence starts again from the crystal after the current one. If every crystal in one pass is rejected, the block stops in a fail state. The analog loop, the search oscillator and the DAC itself are outside this block. The block exposes its state code so that a supervisor can follow progress.

Top module: `pll_acq_seq`

## Requirements
- R1: After reset the block is in IDLE (seqState 0) with xtalSel 0, dacCode 128 and sweepEn 0. A startReq seen in IDLE moves it to SETTLE (seqState 1) with crystal 0. A startReq seen in any state other than IDLE or FAIL has no effect.
- R2: SETTLE lasts exactly SETTLE_CYC cycles, default 16. During SETTLE, lockInhibit and lockDetect are ignored. When SETTLE ends, the block enters ACQUIRE (seqState 2).
- R3: In ACQUIRE, a high lockInhibit advances xtalSel by one, wrapping modulo NUM_XTAL (default 8), and returns to SETTLE. If lockInhibit and lockDetect are both high in the same cycle, lockInhibit wins.
- R4: In ACQUIRE, lockDetect with lockInhibit low enters CONFIRM (seqState 3). The block leaves CONFIRM for RECENTER (seqState 4) only after lockDetect has stayed high for CONFIRM_CYC cycles, default 32. If lockDetect drops during CONFIRM, the block returns to ACQUIRE with the same crystal.
- R5: In CONFIRM and LOCKED, xtalSel never changes, whatever lockInhibit does.
- R6: On entry to RECENTER, dacCode is 128. On each updTick cycle where errZero is low and the code is not at 0 or 255, the code moves by one: down when errNeg is 1, up when errNeg is 0. Without updTick the code holds.
- R7: In RECENTER, an updTick with errZero high enters LOCKED (seqState 5). sweepEn is 1 exactly while in LOCKED.
- R8: In RECENTER, an updTick with errZero low while dacCode is 0 or 255 restarts the sequence. The block goes to SETTLE with the next crystal in order, dacCode 128, and a fresh pass count.
- R9: NUM_XTAL consecutive crystal rejections since the last start or restart put the block in FAIL (seqState 6). A startReq in FAIL starts again from crystal 0.
- R10: A low lockDetect in LOCKED returns the block to ACQUIRE and clears sweepEn on the next cycle. The crystal is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Begin acquisition (honoured in IDLE and FAIL) |
| lockInhibit | input | 1 | Search range exceeded with the current crystal |
| lockDetect | input | 1 | Phase lock detected |
| errNeg | input | 1 | Phase error sign, 1 means lower the correction code |
| errZero | input | 1 | Phase error nulled |
| updTick | input | 1 | Recenter update strobe |
| xtalSel | output | $clog2(NUM_XTAL) | Selected crystal index |
| dacCode | output | DAC_W | Offset-oscillator correction code |
| sweepEn | output | 1 | Sweep path enabled |
| seqState | output | 3 | State code: 0 IDLE, 1 SETTLE, 2 ACQUIRE, 3 CONFIRM, 4 RECENTER, 5 LOCKED, 6 FAIL |

## Verification
Crystal rejection and lock capture can both be reported in the same ACQUIRE cycle. The bench provokes this by holding lockInhibit and lockDetect high through a whole settle interval, so that both are present on the first ACQUIRE cycle. It then expects SETTLE again with the crystal advanced by one, not CONFIRM.

A second collision is between a recenter update and the end of the DAC range. The bench walks the code to 255 and later to 0. It checks that the next update with the error still non-zero restarts on the following crystal and does not wrap the code.

// File: rtl/pll_acq_pkg.sv
package pll_acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SETTLE   = 3'd1,
    ST_ACQ      = 3'd2,
    ST_CONFIRM  = 3'd3,
    ST_RECENTER = 3'd4,
    ST_LOCKED   = 3'd5,
    ST_FAIL     = 3'd6
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic xtalClear;
    logic xtalNext;
    logic passClear;
    logic dacMid;
    logic dacStep;
    logic dacDown;
    logic loadSettle;
    logic loadConfirm;
  } dpStrobe_t;

endpackage

// File: rtl/pll_acq_dp.sv
module pll_acq_dp
  import pll_acq_pkg::*;
#(
  parameter int NUM_XTAL    = 8,
  parameter int DAC_W       = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int CONFIRM_CYC = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   stb,
  output logic [$clog2(NUM_XTAL)-1:0] xtalIdx,
  output logic [DAC_W-1:0]            dacCode,
  output logic                        timerDone,
  output logic                        passLast,
  output logic                        dacAtLimit
);

  localparam int XTAL_W  = $clog2(NUM_XTAL);
  localparam int TMR_MAX = (SETTLE_CYC > CONFIRM_CYC) ? SETTLE_CYC : CONFIRM_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1 << (DAC_W - 1));
  localparam logic [DAC_W-1:0] DAC_MAX = {DAC_W{1'b1}};

  logic [TMR_W-1:0]  tmrCnt;
  logic [XTAL_W-1:0] passCnt;
  logic [XTAL_W-1:0] xtalInc;

  assign xtalInc    = (xtalIdx == XTAL_W'(NUM_XTAL - 1)) ? '0 : xtalIdx + 1'b1;
  assign timerDone  = (tmrCnt == '0);
  assign passLast   = (passCnt == XTAL_W'(NUM_XTAL - 1));
  assign dacAtLimit = (dacCode == '0) || (dacCode == DAC_MAX);

  // shared interval timer for settle and confirm
  always_ff @(posedge clk) begin
    if (!rstN)                tmrCnt <= '0;
    else if (stb.loadSettle)  tmrCnt <= TMR_W'(SETTLE_CYC - 1);
    else if (stb.loadConfirm) tmrCnt <= TMR_W'(CONFIRM_CYC - 1);
    else if (!timerDone)      tmrCnt <= tmrCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              xtalIdx <= '0;
    else if (stb.xtalClear) xtalIdx <= '0;
    else if (stb.xtalNext)  xtalIdx <= xtalInc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              passCnt <= '0;
    else if (stb.passClear) passCnt <= '0;
    else if (stb.xtalNext)  passCnt <= passCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dacCode <= DAC_MID;
    else if (stb.dacMid)  dacCode <= DAC_MID;
    else if (stb.dacStep) dacCode <= stb.dacDown ? dacCode - 1'b1 : dacCode + 1'b1;
  end

  AST_DAC_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    stb.dacStep |-> !dacAtLimit); // R8
  AST_DAC_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dacStep && !stb.dacMid) |=> (dacCode == $past(dacCode) + 1'b1) || (dacCode == $past(dacCode) - 1'b1)); // R6

endmodule

// File: rtl/pll_acq_ctrl.sv
module pll_acq_ctrl
  import pll_acq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      lockInhibit,
  input  logic      lockDetect,
  input  logic      errNeg,
  input  logic      errZero,
  input  logic      updTick,
  input  logic      timerDone,
  input  logic      passLast,
  input  logic      dacAtLimit,
  output seqState_e state,
  output dpStrobe_t stb
);

  seqState_e nextState;

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE, ST_FAIL: begin
        if (startReq) begin
          nextState      = ST_SETTLE;
          stb.xtalClear  = 1'b1;
          stb.passClear  = 1'b1;
          stb.dacMid     = 1'b1;
          stb.loadSettle = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (timerDone) nextState = ST_ACQ;
      end
      ST_ACQ: begin
        if (lockInhibit) begin
          stb.xtalNext = 1'b1;
          if (passLast) begin
            nextState = ST_FAIL;
          end else begin
            nextState      = ST_SETTLE;
            stb.loadSettle = 1'b1;
          end
        end else if (lockDetect) begin
          nextState       = ST_CONFIRM;
          stb.loadConfirm = 1'b1;
        end
      end
      ST_CONFIRM: begin
        if (!lockDetect) begin
          nextState = ST_ACQ;
        end else if (timerDone) begin
          nextState  = ST_RECENTER;
          stb.dacMid = 1'b1;
        end
      end
      ST_RECENTER: begin
        if (updTick) begin
          if (errZero) begin
            nextState = ST_LOCKED;
          end else if (dacAtLimit) begin
            nextState      = ST_SETTLE;
            stb.xtalNext   = 1'b1;
            stb.passClear  = 1'b1;
            stb.dacMid     = 1'b1;
            stb.loadSettle = 1'b1;
          end else begin
            stb.dacStep = 1'b1;
            stb.dacDown = errNeg;
          end
        end
      end
      ST_LOCKED: begin
        if (!lockDetect) nextState = ST_ACQ;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && state inside {ST_SETTLE, ST_CONFIRM, ST_LOCKED}) |=> state != ST_IDLE && state != ST_FAIL); // R1
  AST_CONFIRM_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM && !lockDetect) |=> state == ST_ACQ); // R4

endmodule

// File: rtl/pll_acq_seq.sv
module pll_acq_seq
  import pll_acq_pkg::*;
#(
  parameter int NUM_XTAL    = 8,
  parameter int DAC_W       = 8,
  parameter int SETTLE_CYC  = 16,
  parameter int CONFIRM_CYC = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic                        lockInhibit,
  input  logic                        lockDetect,
  input  logic                        errNeg,
  input  logic                        errZero,
  input  logic                        updTick,
  output logic [$clog2(NUM_XTAL)-1:0] xtalSel,
  output logic [DAC_W-1:0]            dacCode,
  output logic                        sweepEn,
  output logic [2:0]                  seqState
);

  localparam int XTAL_W = $clog2(NUM_XTAL);
  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1 << (DAC_W - 1));
  localparam logic [DAC_W-1:0] DAC_MAX = {DAC_W{1'b1}};

  seqState_e state;
  dpStrobe_t stb;
  logic      timerDone;
  logic      passLast;
  logic      dacAtLimit;

  pll_acq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .lockInhibit(lockInhibit),
    .lockDetect (lockDetect),
    .errNeg     (errNeg),
    .errZero    (errZero),
    .updTick    (updTick),
    .timerDone  (timerDone),
    .passLast   (passLast),
    .dacAtLimit (dacAtLimit),
    .state      (state),
    .stb        (stb)
  );

  pll_acq_dp #(
    .NUM_XTAL   (NUM_XTAL),
    .DAC_W      (DAC_W),
    .SETTLE_CYC (SETTLE_CYC),
    .CONFIRM_CYC(CONFIRM_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .xtalIdx   (xtalSel),
    .dacCode   (dacCode),
    .timerDone (timerDone),
    .passLast  (passLast),
    .dacAtLimit(dacAtLimit)
  );

  assign sweepEn  = (state == ST_LOCKED);
  assign seqState = 3'(state);

  AST_XTAL_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM || state == ST_LOCKED) |=> $stable(xtalSel)); // R5
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE) |=> $stable(xtalSel)); // R2
  AST_SWEEP_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && !lockDetect) |=> !sweepEn); // R10
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECENTER && !updTick) |=> $stable(dacCode)); // R6
  AST_DAC_MID_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIRM && lockDetect && timerDone) |=> dacCode == DAC_MID); // R6
  AST_RESTART_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECENTER && updTick && !errZero && (dacCode == '0 || dacCode == DAC_MAX))
    |=> state == ST_SETTLE &&
        xtalSel == (($past(xtalSel) == XTAL_W'(NUM_XTAL - 1)) ? '0 : $past(xtalSel) + 1'b1)); // R8

endmodule

// File: tb/pll_acq_seq_tb.sv
module pll_acq_seq_tb;

  localparam int NX = 8;
  localparam int SC = 16;
  localparam int CC = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0, lockInhibit = 1'b0, lockDetect = 1'b0;
  logic       errNeg = 1'b0, errZero = 1'b0, updTick = 1'b0;
  logic [2:0] xtalSel;
  logic [7:0] dacCode;
  logic       sweepEn;
  logic [2:0] seqState;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pll_acq_seq u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lockInhibit(lockInhibit),
    .lockDetect(lockDetect), .errNeg(errNeg), .errZero(errZero), .updTick(updTick),
    .xtalSel(xtalSel), .dacCode(dacCode), .sweepEn(sweepEn), .seqState(seqState)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    tick(1);
    startReq = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    chk("R1", "state", seqState, 0);
    chk("R1", "xtal", xtalSel, 0);
    chk("R1", "dac", dacCode, 128);
    chk("R1", "sweep", sweepEn, 0);
    pulseStart();
    chk("R1", "state after start", seqState, 1);
    chk("R1", "xtal after start", xtalSel, 0);
  endtask

  // both flags held through settle; inhibit must win in ACQUIRE
  task automatic t_settle_collide();
    lockInhibit = 1'b1;
    lockDetect  = 1'b1;
    tick(SC - 1);
    chk("R2", "still settling", seqState, 1);
    chk("R2", "xtal untouched in settle", xtalSel, 0);
    tick(1);
    chk("R2", "acquire after settle", seqState, 2);
    tick(1);
    chk("R3", "inhibit wins, back to settle", seqState, 1);
    chk("R3", "xtal advanced", xtalSel, 1);
    lockInhibit = 1'b0;
    lockDetect  = 1'b0;
  endtask

  task automatic t_start_ignored();
    tick(2);
    startReq = 1'b1;
    tick(1);
    startReq = 1'b0;
    tick(SC - 4);
    chk("R1", "start ignored, settle running", seqState, 1);
    chk("R1", "start ignored, xtal kept", xtalSel, 1);
    tick(1);
    chk("R2", "settle ends on schedule", seqState, 2);
  endtask

  task automatic t_confirm_drop();
    lockDetect = 1'b1;
    tick(1);
    chk("R4", "confirm entered", seqState, 3);
    tick(10);
    lockDetect = 1'b0;
    tick(1);
    chk("R4", "drop returns to acquire", seqState, 2);
    chk("R4", "crystal kept", xtalSel, 1);
  endtask

  task automatic t_full_lock();
    lockDetect = 1'b1;
    tick(1);
    lockInhibit = 1'b1;
    tick(CC - 1);
    chk("R4", "confirm still running", seqState, 3);
    chk("R5", "xtal frozen in confirm", xtalSel, 1);
    tick(1);
    chk("R4", "recenter after confirm", seqState, 4);
    chk("R6", "dac midscale on entry", dacCode, 128);
    lockInhibit = 1'b0;
    tick(3);
    chk("R6", "dac holds without tick", dacCode, 128);
    updTick = 1'b1;
    errNeg  = 1'b0;
    tick(5);
    chk("R6", "dac stepped up", dacCode, 133);
    errNeg = 1'b1;
    tick(2);
    chk("R6", "dac stepped down", dacCode, 131);
    errZero = 1'b1;
    tick(1);
    chk("R7", "locked", seqState, 5);
    chk("R7", "sweep on", sweepEn, 1);
    chk("R7", "dac kept at null", dacCode, 131);
    updTick = 1'b0;
    errZero = 1'b0;
    errNeg  = 1'b0;
    lockInhibit = 1'b1;
    tick(5);
    chk("R5", "xtal frozen in locked", xtalSel, 1);
    lockInhibit = 1'b0;
    lockDetect  = 1'b0;
    tick(1);
    chk("R10", "loss returns to acquire", seqState, 2);
    chk("R10", "sweep cleared", sweepEn, 0);
    chk("R10", "crystal kept", xtalSel, 1);
  endtask

  task automatic t_limit_up_and_fail();
    lockDetect = 1'b1;
    tick(1 + CC);
    chk("R4", "recenter reached", seqState, 4);
    updTick = 1'b1;
    errNeg  = 1'b0;
    tick(127);
    chk("R6", "dac at top", dacCode, 255);
    chk("R8", "still recentering at top", seqState, 4);
    tick(1);
    chk("R8", "restart to settle", seqState, 1);
    chk("R8", "next crystal", xtalSel, 2);
    chk("R8", "dac back to mid", dacCode, 128);
    updTick    = 1'b0;
    lockDetect = 1'b0;
    lockInhibit = 1'b1;
    tick(7 * (SC + 1));
    chk("R9", "no fail after 7 rejects", seqState, 1);
    chk("R9", "xtal wrapped", xtalSel, 1);
    tick(SC + 1);
    chk("R9", "fail after full pass", seqState, 6);
    chk("R9", "xtal after full pass", xtalSel, 2);
    lockInhibit = 1'b0;
    pulseStart();
    chk("R9", "restart from fail", seqState, 1);
    chk("R9", "restart crystal 0", xtalSel, 0);
  endtask

  task automatic t_limit_down();
    tick(SC);
    chk("R2", "acquire", seqState, 2);
    lockDetect = 1'b1;
    tick(1 + CC);
    chk("R4", "recenter reached", seqState, 4);
    updTick = 1'b1;
    errNeg  = 1'b1;
    tick(128);
    chk("R6", "dac at bottom", dacCode, 0);
    tick(1);
    chk("R8", "restart at bottom", seqState, 1);
    chk("R8", "next crystal after bottom", xtalSel, 1);
    chk("R8", "dac mid after bottom", dacCode, 128);
    updTick    = 1'b0;
    lockDetect = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_settle_collide();
    t_start_ignored();
    t_confirm_drop();
    t_full_lock();
    t_limit_up_and_fail();
    t_limit_down();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule